// File: doc/BRIEF.md
# Serial Configuration and Status Register Slave

This block is the register front end of a two-channel motor gate controller. A host talks to it over a four-wire serial link made of a frame select, a serial clock, a data input and a data output. Each transaction is a fixed 16-bit frame. The frame carries a direction flag, a 3-bit register index and a 12-bit payload, all sent most significant bit first. Eight 12-bit locations are addressable. Six of them hold configuration that the block decodes into named fields for the current regulator and the gate drivers. One index is unused. The last index is a fault status word: hardware fault inputs set its bits, and software can only clear them.

The serial pins are brought into the system clock domain through synchronisers and then oversampled. The data input is captured on each rising edge of the serial clock. A write takes effect only when the select line drops after exactly sixteen clocks. On a read, the addressed word is captured as soon as the index is known and is then shifted out on the data output.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame is sent most significant bit first and is sampled on rising serial-clock edges while the select is high. Its bit 15 is the direction flag (0 = write, 1 = read), bits 14..12 are the register index, and bits 11..0 are the payload.
- R2: A write frame with exactly 16 rising clocks updates the addressed register. The update happens on the third rising system-clock edge at which the select input is low. No other frame or event changes a configuration field.
- R3: In a read frame, the payload bits on the data input are ignored and the addressed register does not change. The register value is driven on the data output, payload bit 11 first. Each bit is valid before the rising clock edge that the host uses to sample it: payload bit 11 before the 5th rising edge, and so on down to payload bit 0 before the 16th rising edge.
- R4: After reset the registers hold these values: index 0 = 0x301, index 1 = 0x0FF, index 2 = 0x130, index 3 = 0x080, index 4 = 0x010, index 5 = 0x000, index 6 = 0xFA5, index 7 = 0x000.
- R5: Reserved bits read as zero and ignore written values. The writable masks are: index 0 = 0xF01, index 1 = 0x0FF, index 2 = 0x1FF, index 3 = 0x0FF, index 4 = 0x7FF, index 6 = 0xFFF. Index 5 has no writable bits.
- R6: A frame whose select window holds any number of rising clocks other than 16 is discarded.
- R7: The decoded outputs follow these bit positions:
  - index 0: enable = bit 0, sense gain = bits 9..8, dead time = bits 11..10.
  - index 1: torque = bits 7..0.
  - index 2: off time = bits 7..0, mode flag = bit 8.
  - index 3: blanking = bits 7..0.
  - index 4: decay time = bits 7..0, decay mode = bits 10..8.
  - index 6: over-current threshold = bits 1..0, deglitch = bits 3..2, sink time = bits 5..4, source time = bits 7..6, sink current = bits 9..8, source current = bits 11..10.
- R8: A high fault_set bit sets the matching status bit (index 7, bits 5..0), and the bit stays set until software clears it.
- R9: Writing 0 to a status bit clears it. Writing 1 to a status bit has no effect, so software can never set a status bit.
- R10: A fault_set bit that is high on the same clock edge as a status write clearing that bit wins, and the bit stays set.
- R11: The data output is 0 outside the payload phase of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel | input | 1 | Frame select, high during a frame |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| fault_set | input | 6 | Hardware fault set strobes for status bits |
| drv_enable | output | 1 | Bridge enable |
| sense_gain | output | 2 | Sense amplifier gain code |
| dead_time | output | 2 | Dead time code |
| torque | output | 8 | Full-scale current scale |
| off_time | output | 8 | Fixed off time |
| pwm_mode | output | 1 | PWM control mode flag |
| blank_time | output | 8 | Current-trip blanking time |
| decay_time | output | 8 | Mixed decay transition time |
| decay_mode | output | 3 | Decay mode code |
| ocp_thresh | output | 2 | Over-current threshold code |
| ocp_deglitch | output | 2 | Over-current deglitch code |
| gate_sink_time | output | 2 | Gate sink drive time code |
| gate_src_time | output | 2 | Gate source drive time code |
| gate_sink_cur | output | 2 | Gate peak sink current code |
| gate_src_cur | output | 2 | Gate peak source current code |
| status | output | 6 | Sticky fault status bits |

## Verification
Write frames use all-ones payloads to expose the reserved-bit masks, and mixed payloads to show that each decoded field lands in its own slot. Read frames carry junk payload bits, which separates a slave that honours the direction flag from one that overwrites the register during a read. Frames of 15 and 17 clocks separate an exact-length check from a minimum-length check. Status traffic combines fault pulses placed before, on and after the commit edge with payloads of all ones and of selective zeros; this tells set-wins priority and write-one immunity apart from plain register behaviour.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_BITS  = 3;
    localparam int DATA_BITS  = 12;
    localparam int HDR_BITS   = 1 + ADDR_BITS;
    localparam int NUM_REGS   = 1 << ADDR_BITS;
    localparam int STAT_BITS  = 6;

    typedef logic [DATA_BITS-1:0] word_t;
    typedef logic [ADDR_BITS-1:0] addr_t;

    localparam addr_t STAT_ADDR = addr_t'(7);

    typedef struct packed {
        logic  rd;
        addr_t addr;
        word_t data;
    } frame_t;

    typedef struct packed {
        logic       enable;
        logic [1:0] gain;
        logic [1:0] dead;
        logic [7:0] torque;
        logic [7:0] toff;
        logic       pwm_mode;
        logic [7:0] tblank;
        logic [7:0] tdecay;
        logic [2:0] decay_mode;
        logic [1:0] ocp_th;
        logic [1:0] ocp_deg;
        logic [1:0] sink_time;
        logic [1:0] src_time;
        logic [1:0] sink_cur;
        logic [1:0] src_cur;
    } cfg_t;

    function automatic word_t wr_mask(addr_t a);
        case (a)
            3'd0:    return word_t'(12'hF01);
            3'd1:    return word_t'(12'h0FF);
            3'd2:    return word_t'(12'h1FF);
            3'd3:    return word_t'(12'h0FF);
            3'd4:    return word_t'(12'h7FF);
            3'd6:    return word_t'(12'hFFF);
            default: return '0;
        endcase
    endfunction

    function automatic word_t reset_val(addr_t a);
        case (a)
            3'd0:    return word_t'(12'h301);
            3'd1:    return word_t'(12'h0FF);
            3'd2:    return word_t'(12'h130);
            3'd3:    return word_t'(12'h080);
            3'd4:    return word_t'(12'h010);
            3'd6:    return word_t'(12'hFA5);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sel,
    input  logic   sck,
    input  logic   sdi,
    input  word_t  rd_data,
    output addr_t  rd_addr,
    output logic   commit,
    output frame_t wframe,
    output logic   sdo
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_MAX = FRAME_BITS + 1;

    logic sel_s, sck_s, sdi_s;
    logic sel_q, sck_q;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sh;
    word_t                 tx;
    logic                  rd_phase;
    logic                  rise, start, fall;

    bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sel (.clk(clk), .rst(rst), .d(sel), .q(sel_s));
    bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (.clk(clk), .rst(rst), .d(sck), .q(sck_s));
    bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (.clk(clk), .rst(rst), .d(sdi), .q(sdi_s));

    assign rise  = sel_s & sck_s & ~sck_q;
    assign start = sel_s & ~sel_q;
    assign fall  = ~sel_s & sel_q;

    // index is complete once the last address bit arrives on this edge
    assign rd_addr = {sh[ADDR_BITS-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            sck_q    <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            rd_phase <= 1'b0;
        end else begin
            sel_q <= sel_s;
            sck_q <= sck_s;
            if (start) begin
                cnt      <= '0;
                rd_phase <= 1'b0;
            end else if (rise) begin
                sh <= {sh[FRAME_BITS-2:0], sdi_s};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(HDR_BITS - 1)) begin
                    tx       <= rd_data;
                    rd_phase <= sh[ADDR_BITS-1];
                end else begin
                    tx <= {tx[DATA_BITS-2:0], 1'b0};
                end
            end
            if (fall) rd_phase <= 1'b0;
        end
    end

    assign wframe = frame_t'(sh);
    assign commit = fall & (cnt == CNT_W'(FRAME_BITS)) & ~wframe.rd;
    assign sdo    = rd_phase & tx[DATA_BITS-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_cfg_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  addr_t                               wr_addr,
    input  word_t                               wr_data,
    input  addr_t                               rd_addr,
    input  logic [STAT_BITS-1:0]                fault_set,
    output word_t                               rd_data,
    output logic [NUM_REGS-1:0][DATA_BITS-1:0]  regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (addr_t'(i) == STAT_ADDR) begin : g_status
            logic [STAT_BITS-1:0] st;
            logic [STAT_BITS-1:0] clr;
            assign clr = (wr_en && wr_addr == STAT_ADDR) ? ~wr_data[STAT_BITS-1:0] : '0;
            always_ff @(posedge clk) begin
                if (rst) st <= '0;
                else     st <= (st & ~clr) | fault_set;
            end
            assign regs[i] = {{(DATA_BITS-STAT_BITS){1'b0}}, st};
        end else begin : g_cfg
            word_t r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= reset_val(addr_t'(i));
                else if (wr_en && wr_addr == addr_t'(i))
                    r <= wr_data & wr_mask(addr_t'(i));
            end
            assign regs[i] = r;
        end
    end

    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sel,
    input  logic                 spi_sck,
    input  logic                 spi_sdi,
    output logic                 spi_sdo,
    input  logic [STAT_BITS-1:0] fault_set,
    output logic                 drv_enable,
    output logic [1:0]           sense_gain,
    output logic [1:0]           dead_time,
    output logic [7:0]           torque,
    output logic [7:0]           off_time,
    output logic                 pwm_mode,
    output logic [7:0]           blank_time,
    output logic [7:0]           decay_time,
    output logic [2:0]           decay_mode,
    output logic [1:0]           ocp_thresh,
    output logic [1:0]           ocp_deglitch,
    output logic [1:0]           gate_sink_time,
    output logic [1:0]           gate_src_time,
    output logic [1:0]           gate_sink_cur,
    output logic [1:0]           gate_src_cur,
    output logic [STAT_BITS-1:0] status
);
    logic                               wr_commit;
    frame_t                             wr_frame;
    addr_t                              wr_addr;
    addr_t                              rd_addr;
    word_t                              rd_data;
    logic [NUM_REGS-1:0][DATA_BITS-1:0] regs;
    cfg_t                               cfg;

    spi_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .sel     (spi_sel),
        .sck     (spi_sck),
        .sdi     (spi_sdi),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .commit  (wr_commit),
        .wframe  (wr_frame),
        .sdo     (spi_sdo)
    );

    assign wr_addr = wr_frame.addr;

    spi_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_frame.data),
        .rd_addr   (rd_addr),
        .fault_set (fault_set),
        .rd_data   (rd_data),
        .regs      (regs)
    );

    always_comb begin
        cfg.enable     = regs[0][0];
        cfg.gain       = regs[0][9:8];
        cfg.dead       = regs[0][11:10];
        cfg.torque     = regs[1][7:0];
        cfg.toff       = regs[2][7:0];
        cfg.pwm_mode   = regs[2][8];
        cfg.tblank     = regs[3][7:0];
        cfg.tdecay     = regs[4][7:0];
        cfg.decay_mode = regs[4][10:8];
        cfg.ocp_th     = regs[6][1:0];
        cfg.ocp_deg    = regs[6][3:2];
        cfg.sink_time  = regs[6][5:4];
        cfg.src_time   = regs[6][7:6];
        cfg.sink_cur   = regs[6][9:8];
        cfg.src_cur    = regs[6][11:10];
    end

    assign drv_enable     = cfg.enable;
    assign sense_gain     = cfg.gain;
    assign dead_time      = cfg.dead;
    assign torque         = cfg.torque;
    assign off_time       = cfg.toff;
    assign pwm_mode       = cfg.pwm_mode;
    assign blank_time     = cfg.tblank;
    assign decay_time     = cfg.tdecay;
    assign decay_mode     = cfg.decay_mode;
    assign ocp_thresh     = cfg.ocp_th;
    assign ocp_deglitch   = cfg.ocp_deg;
    assign gate_sink_time = cfg.sink_time;
    assign gate_src_time  = cfg.src_time;
    assign gate_sink_cur  = cfg.sink_cur;
    assign gate_src_cur   = cfg.src_cur;
    assign status         = regs[STAT_ADDR][STAT_BITS-1:0];
endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker
    import spi_cfg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [STAT_BITS-1:0] fault_set,
    input logic [STAT_BITS-1:0] status,
    input logic                 wr_commit,
    input addr_t                wr_addr,
    input logic [7:0]           torque,
    input logic [2:0]           decay_mode
);
    // R10: a fault strobe always leaves its bit set on the next cycle
    assert_fault_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (|fault_set) |=> ((status & $past(fault_set)) == $past(fault_set)));

    // R8: without a status write no bit can drop
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_commit && wr_addr == STAT_ADDR) |=> ((status & $past(status)) == $past(status)));

    // R9: a bit can only rise through a fault strobe
    assert_no_sw_set_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(fault_set)) == '0));

    // R2: config changes only after a commit
    assert_torque_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |=> $stable(torque));

    assert_decay_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |=> $stable(decay_mode));

    // R2: one commit per frame
    assert_single_commit_R2: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);
endmodule

bind spi_cfg_slave spi_cfg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault_set  (fault_set),
    .status     (status),
    .wr_commit  (wr_commit),
    .wr_addr    (wr_addr),
    .torque     (torque),
    .decay_mode (decay_mode)
);

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;
    logic clk = 0;
    logic rst = 1;
    logic spi_sel = 0, spi_sck = 0, spi_sdi = 0;
    logic spi_sdo;
    logic [5:0] fault_set = 0;
    logic drv_enable, pwm_mode;
    logic [1:0] sense_gain, dead_time, ocp_thresh, ocp_deglitch;
    logic [1:0] gate_sink_time, gate_src_time, gate_sink_cur, gate_src_cur;
    logic [7:0] torque, off_time, blank_time, decay_time;
    logic [2:0] decay_mode;
    logic [5:0] status;

    always #2.5 clk = ~clk;

    spi_cfg_slave dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_en  = 0;
    bit done    = 0;
    int mdl [8];

    function automatic int mask_of(int a);
        case (a)
            0: return 'hF01; 1: return 'h0FF; 2: return 'h1FF; 3: return 'h0FF;
            4: return 'h7FF; 6: return 'hFFF; default: return 0;
        endcase
    endfunction

    task automatic check_eq(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mdl[0] = 'h301; mdl[1] = 'h0FF; mdl[2] = 'h130; mdl[3] = 'h080;
        mdl[4] = 'h010; mdl[5] = 0;     mdl[6] = 'hFA5; mdl[7] = 0;
    endtask

    // R7: outputs reassembled into words and compared on every clock
    always @(negedge clk) begin
        if (chk_en && !rst && !done) begin
            check_eq("R7 idx0", {20'b0, dead_time, sense_gain, 7'b0, drv_enable}, mdl[0]);
            check_eq("R7 idx1", {24'b0, torque}, mdl[1]);
            check_eq("R7 idx2", {23'b0, pwm_mode, off_time}, mdl[2]);
            check_eq("R7 idx3", {24'b0, blank_time}, mdl[3]);
            check_eq("R7 idx4", {21'b0, decay_mode, decay_time}, mdl[4]);
            check_eq("R7 idx6", {20'b0, gate_src_cur, gate_sink_cur, gate_src_time,
                                 gate_sink_time, ocp_deglitch, ocp_thresh}, mdl[6]);
            check_eq("R8 status", {26'b0, status}, mdl[7]);
        end
    end

    task automatic frame(input bit rd, input int a, input int d, input int nclk,
                         input int f_off, input logic [5:0] fbits,
                         output logic [11:0] rbits, output bit quiet);
        logic [15:0] f;
        f = {rd, a[2:0], d[11:0]};
        rbits = 0;
        quiet = 1;
        chk_en = 0;
        @(negedge clk) spi_sel = 1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            spi_sdi = (i < 16) ? f[15-i] : 1'b0;
            repeat (2) @(negedge clk);
            if (rd && i >= 4 && i < 16) rbits[15-i] = spi_sdo;
            else if (spi_sdo) quiet = 0;
            repeat (2) @(negedge clk);
            spi_sck = 1;
            repeat (4) @(negedge clk);
            spi_sck = 0;
        end
        repeat (4) @(negedge clk);
        spi_sel = 0;
        for (int k = 0; k < 8; k++) begin
            fault_set = (k == f_off) ? fbits : 6'b0;
            @(negedge clk);
        end
        fault_set = 0;
        // model: commit lands with the strobe sent at offset 2
        if (f_off >= 0 && f_off < 2) mdl[7] |= fbits;
        if (nclk == 16 && !rd) begin
            if (a == 7) mdl[7] &= d[5:0];
            else        mdl[a] = d & mask_of(a);
        end
        if (f_off >= 2) mdl[7] |= fbits;
        repeat (2) @(negedge clk);
        chk_en = 1;
    endtask

    task automatic wr(input int a, input int d, input string req);
        logic [11:0] r; bit q;
        frame(0, a, d, 16, -1, 0, r, q);
        check_eq({req, " R11 sdo idle on write"}, q, 1);
    endtask

    task automatic rd_chk(input int a, input string req);
        logic [11:0] r; bit q;
        frame(1, a, 'hA5C, 16, -1, 0, r, q);
        check_eq(req, r, mdl[a]);
    endtask

    task automatic pulse(input logic [5:0] b);
        chk_en = 0;
        @(negedge clk) fault_set = b;
        @(negedge clk) fault_set = 0;
        mdl[7] |= b;
        repeat (2) @(negedge clk);
        chk_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] r; bit q;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R4 reset state at the ports
        check_eq("R4 torque", torque, 'hFF);
        check_eq("R4 ocp/gate", {gate_src_cur, gate_sink_cur, gate_src_time, gate_sink_time,
                                 ocp_deglitch, ocp_thresh}, 'hFA5);
        check_eq("R4 enable", drv_enable, 1);
        check_eq("R11 sdo idle", spi_sdo, 0);
        chk_en = 1;
        for (int a = 0; a < 8; a++) rd_chk(a, "R4 R3 reset readback");

        wr(1, 'hFFF, "R5");
        rd_chk(1, "R5 reserved bits of idx1");
        wr(0, 'hC02, "R7");
        check_eq("R7 enable cleared", drv_enable, 0);
        check_eq("R7 dead time", dead_time, 3);
        rd_chk(0, "R5 idx0 mask");
        wr(6, 'h5A3, "R1");
        rd_chk(6, "R1 frame order");
        wr(4, 'hDAB, "R2");
        check_eq("R2 decay mode", decay_mode, 5);
        wr(2, 'hE47, "R2");
        wr(3, 'h312, "R2");
        wr(5, 'hFFF, "R5");
        rd_chk(5, "R5 idx5 reads zero");

        // R6 short and long frames
        frame(0, 1, 'h012, 15, -1, 0, r, q);
        check_eq("R6 15-clock frame", torque, 'hFF);
        frame(0, 1, 'h034, 17, -1, 0, r, q);
        check_eq("R6 17-clock frame", torque, 'hFF);

        // R3 read payload ignored
        rd_chk(2, "R3 read value");
        check_eq("R3 register unchanged", off_time, 'h47);

        // status
        pulse(6'h15);
        check_eq("R8 fault set", status, 'h15);
        rd_chk(7, "R8 status readback");
        wr(7, 'hFFF, "R9");
        check_eq("R9 write one no effect", status, 'h15);
        wr(7, 'h03B, "R9");
        check_eq("R9 write zero clears", status, 'h11);
        frame(0, 7, 'h000, 16, 2, 6'h01, r, q);
        check_eq("R10 set wins over clear", status, 'h01);
        frame(0, 7, 'h000, 16, 0, 6'h20, r, q);
        check_eq("R2 R10 early strobe then clear", status, 'h00);
        frame(0, 7, 'h000, 16, 5, 6'h02, r, q);
        check_eq("R8 late strobe", status, 'h02);
        rd_chk(7, "R3 status read");

        repeat (10) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule